// File: doc/BRIEF.md
# Haar Feature Evaluator

This block scores one Haar-like rectangle feature for one detection window of a cascade face detector. A request carries the window origin in the integral image, a descriptor of two or three rectangles placed inside a 24×24 window, a signed threshold and two leaf values. Each rectangle is given as an offset, a size and a small signed weight.

For each rectangle the block reads four integral-image entries through a single-port synchronous memory port with one cycle of read latency. It turns them into the pixel total of the rectangle and adds the weighted totals into a signed feature value. Giving the dark region a positive weight and the light region a negative one produces the usual dark-minus-light response. The block then compares this value with the threshold and returns one of the two leaf values as the weak-classifier vote.

The four basic shapes are written as ordinary rectangle lists: two side by side, two stacked, three side by side and three stacked. The rectangle weights and sizes come from offline training. Requests use a valid/ready handshake, and the result comes back as a one-cycle pulse.

Top module: `haar_feat_eval`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A request is taken only at a clock edge where `req_valid` and `req_ready` are both high. A `req_valid` pulse while `req_ready` is low has no effect on reads or on the vote.
- R2: Reads are issued one per cycle, starting in the cycle after the acceptance edge. The rectangles are read in index order 0, 1, 2. Within each rectangle the four corners are read in this order, with top = origin row + y, bottom = top + h − 1, left = origin column + x, right = left + w − 1:
  - A at (top−1, left−1)
  - B at (top−1, right)
  - C at (bottom, left−1)
  - D at (bottom, right)

  The memory address is row × IMG_W + column.
- R3: A corner whose row or column is −1 contributes zero, and `mem_rd_en` is low in that corner's read slot.
- R4: The feature value is the sum over the rectangles of weight × (D − B − C + A). This equals the weighted pixel total of each rectangle. Rectangle k takes its x, y, w and h from bits [k·CRD_W +: CRD_W] of `req_x`, `req_y`, `req_w` and `req_h`. Its weight is a two's-complement number at bits [k·WGT_W +: WGT_W] of `req_wgt`.
- R5: When `req_three` is 0, only rectangles 0 and 1 are used, which takes 8 read slots, and the fields of rectangle 2 have no effect. When `req_three` is 1, all three rectangles are used, which takes 12 read slots.
- R6: The vote is `req_leaf_lt` when the feature value is below the signed threshold. Otherwise the vote is `req_leaf_ge`, so a value equal to the threshold gives `req_leaf_ge`. `out_vote` holds its value between results.
- R7: `out_valid` is high for exactly one cycle, 4·K + 3 clock edges after the acceptance edge, where K is the number of rectangles. `req_ready` rises in the same cycle, and a waiting request is taken at the next edge.
- R8: The value does not overflow at the extremes. With every pixel at 255 and three full 24×24 rectangles of weight +3 (or −3), the value is exactly +1 321 920 (or −1 321 920).
- R9: After reset, `req_ready` is 1, `out_valid` is 0 and `mem_rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_row | input | ROW_W | Window origin row in the integral image |
| req_col | input | COL_W | Window origin column in the integral image |
| req_three | input | 1 | 1 = three rectangles, 0 = two rectangles |
| req_x | input | 3·CRD_W | Column offsets of the rectangles inside the window |
| req_y | input | 3·CRD_W | Row offsets of the rectangles inside the window |
| req_w | input | 3·CRD_W | Rectangle widths |
| req_h | input | 3·CRD_W | Rectangle heights |
| req_wgt | input | 3·WGT_W | Signed rectangle weights |
| req_thr | input | FEAT_W | Signed feature threshold |
| req_leaf_lt | input | LEAF_W | Vote returned when the value is below the threshold |
| req_leaf_ge | input | LEAF_W | Vote returned otherwise |
| mem_rd_en | output | 1 | Integral-image read enable |
| mem_rd_addr | output | ADDR_W | Integral-image read address |
| mem_rd_data | input | II_W | Read data, valid one cycle after the address |
| out_valid | output | 1 | One-cycle result strobe |
| out_vote | output | LEAF_W | Selected leaf value |

## Verification
Delivering a result and accepting the next request can fall on neighbouring clock edges. The cycle in which `out_valid` pulses is also the first cycle with `req_ready` high, so a request that has been waiting is taken at the very next edge. At that point the accumulator is cleared while the vote register still holds the previous answer.

The bench provokes this by holding `req_valid` high with a second descriptor throughout the first evaluation. Its cycle model then checks three things on every clock: the pulse, the ready level and the next address stream. A separate case pulses `req_valid` while the block is busy and expects nothing to change.

// File: rtl/haar_pkg.sv
package haar_pkg;
  localparam int NRECT        = 3;
  localparam int CRN_PER_RECT = 4;

  typedef enum logic [1:0] {CRN_A, CRN_B, CRN_C, CRN_D} corner_e;
  typedef enum logic {ST_IDLE, ST_RUN} fsm_e;

  // B and C enter the rectangle total with a negative sign
  function automatic logic corner_neg(corner_e c);
    return (c == CRN_B) || (c == CRN_C);
  endfunction
endpackage

// File: rtl/haar_corner_gen.sv
module haar_corner_gen
  import haar_pkg::*;
#(
  parameter int IMG_W  = 64,
  parameter int ROW_W  = 6,
  parameter int COL_W  = 6,
  parameter int CRD_W  = 5,
  parameter int ADDR_W = 12
) (
  input  logic [ROW_W-1:0]  win_row,
  input  logic [COL_W-1:0]  win_col,
  input  logic [CRD_W-1:0]  rx,
  input  logic [CRD_W-1:0]  ry,
  input  logic [CRD_W-1:0]  rw,
  input  logic [CRD_W-1:0]  rh,
  input  corner_e           crn,
  output logic [ADDR_W-1:0] addr,
  output logic              skip,
  output logic              neg
);
  localparam int RX = ROW_W + 1;
  localparam int CX = COL_W + 1;

  logic [RX-1:0] top_r, bot_r, row;
  logic [CX-1:0] lft_c, rgt_c, col;
  logic          use_top, use_left;

  always_comb begin
    top_r    = RX'(win_row) + RX'(ry);
    bot_r    = top_r + RX'(rh) - RX'(1);
    lft_c    = CX'(win_col) + CX'(rx);
    rgt_c    = lft_c + CX'(rw) - CX'(1);
    use_top  = (crn == CRN_A) || (crn == CRN_B);
    use_left = (crn == CRN_A) || (crn == CRN_C);
    row      = use_top  ? top_r - RX'(1) : bot_r;
    col      = use_left ? lft_c - CX'(1) : rgt_c;
    skip     = (use_top && (top_r == '0)) || (use_left && (lft_c == '0));
    neg      = corner_neg(crn);
    addr     = skip ? '0 : ADDR_W'(int'(row) * IMG_W + int'(col));
  end
endmodule

// File: rtl/haar_accum.sv
module haar_accum #(
  parameter int II_W  = 20,
  parameter int CF_W  = 4,
  parameter int ACC_W = 26
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [CF_W-1:0]  coef,
  input  logic [II_W-1:0]         data,
  output logic signed [ACC_W-1:0] acc
);
  logic signed [ACC_W-1:0] coef_x, data_x;

  assign coef_x = ACC_W'(coef);
  assign data_x = ACC_W'($signed({1'b0, data}));

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (en)    acc <= acc + coef_x * data_x;
  end
endmodule

// File: rtl/haar_vote.sv
module haar_vote #(
  parameter int ACC_W  = 26,
  parameter int FEAT_W = 22,
  parameter int LEAF_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fire,
  input  logic signed [ACC_W-1:0]  acc,
  input  logic signed [FEAT_W-1:0] thr,
  input  logic signed [LEAF_W-1:0] leaf_lt,
  input  logic signed [LEAF_W-1:0] leaf_ge,
  output logic                     out_valid,
  output logic signed [LEAF_W-1:0] out_vote
);
  logic signed [ACC_W-1:0] thr_x;
  assign thr_x = ACC_W'(thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_vote  <= '0;
    end else begin
      out_valid <= fire;
      if (fire) out_vote <= (acc < thr_x) ? leaf_lt : leaf_ge;
    end
  end
endmodule

// File: rtl/haar_feat_eval.sv
module haar_feat_eval
  import haar_pkg::*;
#(
  parameter  int IMG_W  = 64,
  parameter  int IMG_H  = 64,
  parameter  int WIN    = 24,
  parameter  int PIX_W  = 8,
  parameter  int LEAF_W = 16,
  parameter  int WGT_W  = 3,
  localparam int ROW_W  = $clog2(IMG_H),
  localparam int COL_W  = $clog2(IMG_W),
  localparam int ADDR_W = $clog2(IMG_W * IMG_H),
  localparam int CRD_W  = $clog2(WIN + 1),
  localparam int II_W   = PIX_W + ADDR_W,
  localparam int FEAT_W = PIX_W + 2 * $clog2(WIN) + 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ROW_W-1:0]           req_row,
  input  logic [COL_W-1:0]           req_col,
  input  logic                       req_three,
  input  logic [NRECT*CRD_W-1:0]     req_x,
  input  logic [NRECT*CRD_W-1:0]     req_y,
  input  logic [NRECT*CRD_W-1:0]     req_w,
  input  logic [NRECT*CRD_W-1:0]     req_h,
  input  logic [NRECT*WGT_W-1:0]     req_wgt,
  input  logic signed [FEAT_W-1:0]   req_thr,
  input  logic signed [LEAF_W-1:0]   req_leaf_lt,
  input  logic signed [LEAF_W-1:0]   req_leaf_ge,
  output logic                       mem_rd_en,
  output logic [ADDR_W-1:0]          mem_rd_addr,
  input  logic [II_W-1:0]            mem_rd_data,
  output logic                       out_valid,
  output logic signed [LEAF_W-1:0]   out_vote
);
  localparam int ACC_W = II_W + 6;
  localparam int CF_W  = WGT_W + 1;
  localparam int IDX_W = $clog2(NRECT * CRN_PER_RECT + 1);
  localparam int RI_W  = IDX_W - 2;

  fsm_e                    st;
  logic [IDX_W-1:0]        idx, n_reads;
  logic                    accept, fire;

  // latched request
  logic [ROW_W-1:0]        q_row;
  logic [COL_W-1:0]        q_col;
  logic [NRECT*CRD_W-1:0]  q_x, q_y, q_w, q_h;
  logic [NRECT*WGT_W-1:0]  q_wgt;
  logic signed [FEAT_W-1:0] q_thr;
  logic signed [LEAF_W-1:0] q_lt, q_ge;

  // per-rectangle views
  logic [CRD_W-1:0]        rx_a [NRECT];
  logic [CRD_W-1:0]        ry_a [NRECT];
  logic [CRD_W-1:0]        rw_a [NRECT];
  logic [CRD_W-1:0]        rh_a [NRECT];
  logic signed [WGT_W-1:0] wg_a [NRECT];

  genvar g;
  generate
    for (g = 0; g < NRECT; g++) begin : g_rect
      assign rx_a[g] = q_x[g*CRD_W +: CRD_W];
      assign ry_a[g] = q_y[g*CRD_W +: CRD_W];
      assign rw_a[g] = q_w[g*CRD_W +: CRD_W];
      assign rh_a[g] = q_h[g*CRD_W +: CRD_W];
      assign wg_a[g] = q_wgt[g*WGT_W +: WGT_W];
    end
  endgenerate

  // current read slot
  logic [RI_W-1:0]         ri, rsel;
  corner_e                 crn;
  logic [ADDR_W-1:0]       cg_addr;
  logic                    cg_skip, cg_neg;
  logic signed [WGT_W-1:0] cur_w;

  assign ri    = idx[IDX_W-1:2];
  assign rsel  = (int'(ri) >= NRECT) ? '0 : ri;
  assign crn   = corner_e'(idx[1:0]);
  assign cur_w = wg_a[rsel];

  haar_corner_gen #(
    .IMG_W(IMG_W), .ROW_W(ROW_W), .COL_W(COL_W), .CRD_W(CRD_W), .ADDR_W(ADDR_W)
  ) u_corner (
    .win_row(q_row), .win_col(q_col),
    .rx(rx_a[rsel]), .ry(ry_a[rsel]), .rw(rw_a[rsel]), .rh(rh_a[rsel]),
    .crn(crn), .addr(cg_addr), .skip(cg_skip), .neg(cg_neg)
  );

  // read pipeline: s1 = address on the port, s2 = data returned
  logic                   s1_v, s2_v;
  logic signed [CF_W-1:0] s1_coef, s2_coef;
  logic signed [ACC_W-1:0] acc;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign fire      = (st == ST_RUN) && (idx == n_reads) && !s1_v && !s2_v;

  always_ff @(posedge clk) begin
    if (accept) begin
      q_row <= req_row;    q_col <= req_col;
      q_x   <= req_x;      q_y   <= req_y;
      q_w   <= req_w;      q_h   <= req_h;
      q_wgt <= req_wgt;    q_thr <= req_thr;
      q_lt  <= req_leaf_lt; q_ge <= req_leaf_ge;
      n_reads <= IDX_W'(CRN_PER_RECT * (req_three ? NRECT : NRECT - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      idx         <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      s1_v        <= 1'b0;
      s2_v        <= 1'b0;
      s1_coef     <= '0;
      s2_coef     <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      s1_v      <= 1'b0;
      s2_v      <= s1_v;
      s2_coef   <= s1_coef;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            st  <= ST_RUN;
            idx <= '0;
          end
        end
        ST_RUN: begin
          if (idx != n_reads) begin
            mem_rd_en   <= !cg_skip;
            mem_rd_addr <= cg_addr;
            s1_v        <= 1'b1;
            s1_coef     <= cg_skip ? '0 : (cg_neg ? -CF_W'(cur_w) : CF_W'(cur_w));
            idx         <= idx + IDX_W'(1);
          end else if (!s1_v && !s2_v) begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  haar_accum #(.II_W(II_W), .CF_W(CF_W), .ACC_W(ACC_W)) u_accum (
    .clk(clk), .rst(rst), .clr(accept), .en(s2_v),
    .coef(s2_coef), .data(mem_rd_data), .acc(acc)
  );

  haar_vote #(.ACC_W(ACC_W), .FEAT_W(FEAT_W), .LEAF_W(LEAF_W)) u_vote (
    .clk(clk), .rst(rst), .fire(fire), .acc(acc), .thr(q_thr),
    .leaf_lt(q_lt), .leaf_ge(q_ge), .out_valid(out_valid), .out_vote(out_vote)
  );
endmodule

// File: rtl/haar_feat_eval_chk.sv
module haar_feat_eval_chk #(
  parameter int ADDR_W = 12,
  parameter int LEAF_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              out_valid,
  input logic [LEAF_W-1:0] out_vote
);
  // R1: idle block issues no reads
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_rd_en);

  // R1: an accepted request makes the block busy
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid) |=> !req_ready);

  // R7: result strobe lasts one cycle
  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R7: ready returns together with the result
  p_done_ready_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> req_ready);

  // R6: vote only moves with a result
  p_vote_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_vote));

  // R2: address port is quiet once the read enable drops
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!mem_rd_en && req_ready) |=> ($stable(mem_rd_addr) || mem_rd_en || !req_ready));
endmodule

bind haar_feat_eval haar_feat_eval_chk #(.ADDR_W(ADDR_W), .LEAF_W(LEAF_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
  .out_valid(out_valid), .out_vote(out_vote)
);

// File: tb/haar_feat_eval_bench.sv
module haar_feat_eval_bench;
  localparam int IMG_W  = 64;
  localparam int IMG_H  = 64;
  localparam int WIN    = 24;
  localparam int PIX_W  = 8;
  localparam int LEAF_W = 16;
  localparam int WGT_W  = 3;
  localparam int NR     = 3;
  localparam int ROW_W  = $clog2(IMG_H);
  localparam int COL_W  = $clog2(IMG_W);
  localparam int ADDR_W = $clog2(IMG_W * IMG_H);
  localparam int CRD_W  = $clog2(WIN + 1);
  localparam int II_W   = PIX_W + ADDR_W;
  localparam int FEAT_W = PIX_W + 2 * $clog2(WIN) + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_three = 1'b0;
  logic [NR*CRD_W-1:0] req_x = '0, req_y = '0, req_w = '0, req_h = '0;
  logic [NR*WGT_W-1:0] req_wgt = '0;
  logic signed [FEAT_W-1:0] req_thr = '0;
  logic signed [LEAF_W-1:0] req_leaf_lt = '0, req_leaf_ge = '0;
  logic mem_rd_en;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic [II_W-1:0] mem_rd_data = '0;
  logic out_valid;
  logic signed [LEAF_W-1:0] out_vote;

  always #10 clk = ~clk;

  haar_feat_eval u_haar_feat_eval (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_three(req_three),
    .req_x(req_x), .req_y(req_y), .req_w(req_w), .req_h(req_h), .req_wgt(req_wgt),
    .req_thr(req_thr), .req_leaf_lt(req_leaf_lt), .req_leaf_ge(req_leaf_ge),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .out_valid(out_valid), .out_vote(out_vote)
  );

  // integral image memory, one-cycle read latency
  logic [II_W-1:0] iimg [IMG_W*IMG_H];
  int pix [IMG_H][IMG_W];
  always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= iimg[mem_rd_addr];

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string cur_tag = "R4";

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic load_image(input bit full);
    int unsigned seed;
    seed = 32'h1234_5678;
    for (int r = 0; r < IMG_H; r++)
      for (int c = 0; c < IMG_W; c++) begin
        seed = seed * 1103515245 + 12345;
        pix[r][c] = full ? 255 : int'((seed >> 16) & 255);
      end
    for (int r = 0; r < IMG_H; r++) begin
      int run;
      run = 0;
      for (int c = 0; c < IMG_W; c++) begin
        run += pix[r][c];
        iimg[r*IMG_W+c] = II_W'(run + ((r > 0) ? int'(iimg[(r-1)*IMG_W+c]) : 0));
      end
    end
  endtask

  task automatic set_rect(input int i, input int x, input int y, input int w, input int h, input int wg);
    req_x[i*CRD_W +: CRD_W] = CRD_W'(x);
    req_y[i*CRD_W +: CRD_W] = CRD_W'(y);
    req_w[i*CRD_W +: CRD_W] = CRD_W'(w);
    req_h[i*CRD_W +: CRD_W] = CRD_W'(h);
    req_wgt[i*WGT_W +: WGT_W] = WGT_W'(wg);
  endtask

  task automatic set_req(input int row, input int col, input bit three, input int lt, input int ge);
    req_row = ROW_W'(row);
    req_col = COL_W'(col);
    req_three = three;
    req_leaf_lt = LEAF_W'(lt);
    req_leaf_ge = LEAF_W'(ge);
  endtask

  // feature value from pixels directly (R4, R5)
  function automatic int feat_value();
    int v, kn;
    v = 0;
    kn = req_three ? 3 : 2;
    for (int k = 0; k < kn; k++) begin
      int s, r0, c0, hh, ww;
      s  = 0;
      r0 = int'(req_row) + int'(req_y[k*CRD_W +: CRD_W]);
      c0 = int'(req_col) + int'(req_x[k*CRD_W +: CRD_W]);
      hh = int'(req_h[k*CRD_W +: CRD_W]);
      ww = int'(req_w[k*CRD_W +: CRD_W]);
      for (int r = r0; r < r0 + hh; r++)
        for (int c = c0; c < c0 + ww; c++) s += pix[r][c];
      v += int'($signed(req_wgt[k*WGT_W +: WGT_W])) * s;
    end
    return v;
  endfunction

  // cycle model
  bit m_busy = 1'b0, e_valid = 1'b0;
  int m_t = 0, m_n = 0, m_vote = 0;
  int m_addr [12];
  bit m_en [12];
  string m_tag = "";

  always @(posedge clk) begin
    e_valid = 1'b0;
    if (rst) m_busy = 1'b0;
    else if (m_busy) begin
      m_t++;
      if (m_t == m_n + 3) begin
        m_busy = 1'b0;
        e_valid = 1'b1;
      end
    end else if (req_valid) begin
      int v;
      m_busy = 1'b1;
      m_t = 0;
      m_n = req_three ? 12 : 8;
      m_tag = cur_tag;
      v = feat_value();
      m_vote = (v < int'(req_thr)) ? int'(req_leaf_lt) : int'(req_leaf_ge);
      for (int k = 0; k < m_n / 4; k++) begin
        int tr, br, lc, rc;
        tr = int'(req_row) + int'(req_y[k*CRD_W +: CRD_W]);
        br = tr + int'(req_h[k*CRD_W +: CRD_W]) - 1;
        lc = int'(req_col) + int'(req_x[k*CRD_W +: CRD_W]);
        rc = lc + int'(req_w[k*CRD_W +: CRD_W]) - 1;
        for (int q = 0; q < 4; q++) begin
          int rr, cc;
          rr = (q < 2) ? tr - 1 : br;
          cc = (q == 0 || q == 2) ? lc - 1 : rc;
          m_en[k*4+q]   = (rr >= 0) && (cc >= 0);
          m_addr[k*4+q] = rr * IMG_W + cc;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      bit ee;
      chk(req_ready == !m_busy, "R1 req_ready", int'(req_ready), int'(!m_busy));
      chk(out_valid == e_valid, "R7 out_valid", int'(out_valid), int'(e_valid));
      if (e_valid && out_valid)
        chk(int'(out_vote) == m_vote, {m_tag, " R6 out_vote"}, int'(out_vote), m_vote);
      ee = m_busy && (m_t >= 1) && (m_t <= m_n) && m_en[m_t-1];
      chk(mem_rd_en == ee, "R3 mem_rd_en", int'(mem_rd_en), int'(ee));
      if (ee && mem_rd_en)
        chk(int'(mem_rd_addr) == m_addr[m_t-1], "R2 mem_rd_addr", int'(mem_rd_addr), m_addr[m_t-1]);
    end
  end

  task automatic send(input bit keep);
    bit rdy;
    req_valid = 1'b1;
    forever begin
      rdy = req_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    @(negedge clk);
    if (!keep) req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(req_ready == 1'b1, "R9 req_ready", int'(req_ready), 1);
    chk(out_valid == 1'b0, "R9 out_valid", int'(out_valid), 0);
    chk(mem_rd_en == 1'b0, "R9 mem_rd_en", int'(mem_rd_en), 0);
    rst = 1'b0;
    load_image(1'b0);
    @(negedge clk);

    // R3: two side by side at the image corner, edge corners read as zero
    cur_tag = "R3";
    set_req(0, 0, 1'b0, -11, 22);
    set_rect(0, 0, 0, 12, 24, -1); set_rect(1, 12, 0, 12, 24, 1);
    req_thr = '0;
    send(1'b0); wait_idle();

    // R2: two stacked at an interior window
    cur_tag = "R2";
    set_req(10, 20, 1'b0, -3, 4);
    set_rect(0, 0, 0, 24, 12, 1); set_rect(1, 0, 12, 24, 12, -1);
    req_thr = FEAT_W'(100);
    send(1'b0); wait_idle();

    // R4: three side by side
    cur_tag = "R4";
    set_req(30, 37, 1'b1, 5, -6);
    set_rect(0, 0, 2, 8, 20, -1); set_rect(1, 8, 2, 8, 20, 2); set_rect(2, 16, 2, 8, 20, -1);
    req_thr = FEAT_W'(-50);
    send(1'b0); wait_idle();

    // R4: three stacked, top row on image edge
    set_req(0, 40, 1'b1, 7, 8);
    set_rect(0, 3, 0, 18, 8, 1); set_rect(1, 3, 8, 18, 8, -2); set_rect(2, 3, 16, 18, 8, 1);
    req_thr = FEAT_W'(0);
    send(1'b0); wait_idle();

    // R6: threshold equal selects the upper leaf, one above selects the lower
    cur_tag = "R6";
    set_req(10, 20, 1'b0, -100, 100);
    set_rect(0, 0, 0, 24, 12, 1); set_rect(1, 0, 12, 24, 12, -1);
    req_thr = FEAT_W'(feat_value());
    send(1'b0); wait_idle();
    req_thr = FEAT_W'(feat_value() + 1);
    send(1'b0); wait_idle();

    // R5: rectangle 2 has no effect in two-rectangle mode
    cur_tag = "R5";
    set_req(5, 5, 1'b0, 31, 32);
    set_rect(0, 2, 2, 6, 6, 3); set_rect(1, 8, 2, 6, 6, -3); set_rect(2, 0, 0, 24, 24, 3);
    req_thr = FEAT_W'(feat_value());
    req_three = 1'b0;
    send(1'b0); wait_idle();

    // R1: a request pulse while busy is ignored
    cur_tag = "R1";
    set_req(12, 12, 1'b1, 41, 42);
    set_rect(0, 0, 0, 8, 24, 1); set_rect(1, 8, 0, 8, 24, -1); set_rect(2, 16, 0, 8, 24, 1);
    req_thr = FEAT_W'(1);
    send(1'b0);
    repeat (3) @(negedge clk);
    set_req(0, 0, 1'b0, 99, 98);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();

    // R7: back-to-back, second request waits and is taken after the pulse
    cur_tag = "R7";
    set_req(20, 30, 1'b0, 51, 52);
    set_rect(0, 0, 0, 12, 12, 2); set_rect(1, 12, 12, 12, 12, -2);
    req_thr = FEAT_W'(0);
    send(1'b1);
    set_req(1, 1, 1'b1, 61, 62);
    set_rect(0, 0, 0, 4, 4, 1); set_rect(1, 4, 0, 4, 4, -1); set_rect(2, 8, 0, 4, 4, 1);
    req_thr = FEAT_W'(200);
    send(1'b0); wait_idle();

    // R8: extreme values with a saturated image
    cur_tag = "R8";
    load_image(1'b1);
    set_req(40, 40, 1'b1, -1, 1);
    set_rect(0, 0, 0, 24, 24, 3); set_rect(1, 0, 0, 24, 24, 3); set_rect(2, 0, 0, 24, 24, 3);
    chk(feat_value() == 1321920, "R8 bench value", feat_value(), 1321920);
    req_thr = FEAT_W'(1321920);
    send(1'b0); wait_idle();
    set_rect(0, 0, 0, 24, 24, -3); set_rect(1, 0, 0, 24, 24, -3); set_rect(2, 0, 0, 24, 24, -3);
    req_thr = FEAT_W'(-1321919);
    send(1'b0); wait_idle();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule